// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central hazard controller for an out-of-order execution core that has no renaming. It keeps a status entry for each of five functional units and an owner table for 32 architectural registers. The front end presents one decoded instruction at a time, in program order. The controller either accepts it or holds it with a stall. Execution units wait for a read permission before they fetch operands from the register file, and for a write permission before they store their result.

Structural and write-after-write conflicts are settled when an instruction is accepted. Read-after-write conflicts are settled at operand fetch. Write-after-read conflicts are settled at result write. Results are never forwarded, so a consumer fetches from the register file only after its producer has written. The datapath signals the end of execution with a one-cycle pulse for each unit, so execution latency lies outside the block. The controller reports to the datapath the operation code held by each unit.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: Instructions are accepted strictly in order. While `issue_stall` is high, no unit is loaded, and the presented instruction stays at the head until it is accepted.
- R2: Each instruction names a class in `iss_cls`: 0 integer, 1 multiply, 2 add, 3 divide. Unit bits in `read_grant`, `wb_grant` and `exec_done` are: bit 0 integer, bit 1 multiplier A, bit 2 multiplier B, bit 3 adder, bit 4 divider. A multiply takes the lowest-numbered free multiplier. `issue_stall` is raised when no unit of the requested class is free.
- R3: `issue_stall` is raised while the destination register is owned by an active instruction, and the stall holds until that owner has written back.
- R4: On acceptance the unit records the operation, the destination and both sources. Each source is marked ready when no active unit owns it, and the destination's owner slot is set to the accepted unit.
- R5: A unit gets `read_grant` for one cycle once both of its sources are ready. After that grant its ready flags and producer tags are cleared, and it waits for `exec_done`.
- R6: A unit that has completed is given `wb_grant` only when no other busy unit still has a ready, unread source equal to its destination.
- R7: A write-back marks ready every source that waits on the writing unit. It frees the destination's owner slot and the unit, so a dependent unit reads no earlier than the cycle after the write-back.
- R8: Every unit that meets its read or write condition is granted in the same cycle. Two readers released by the same write-back are both read-granted together.
- R9: While reset is high and after it is released, all grants are low and `issue_stall` is low with `iss_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is presented |
| iss_op | input | 4 | Operation code, stored with the unit |
| iss_cls | input | 2 | Unit class of the instruction |
| iss_dst | input | 5 | Destination register |
| iss_src1 | input | 5 | First source register |
| iss_src2 | input | 5 | Second source register |
| exec_done | input | 5 | One-cycle end-of-execution pulse for each unit |
| issue_stall | output | 1 | The presented instruction is not accepted this cycle |
| read_grant | output | 5 | Operand-fetch permission for each unit |
| wb_grant | output | 5 | Result-write permission for each unit |
| unit_op | output | 20 | Operation code held by each unit, 4 bits per unit, unit 0 lowest |

## Verification
Internal state errors show up at the ports within a few cycles. A wrong ready flag or producer tag makes a read grant arrive too early, before the producer's write grant, or never arrive at all. A stale owner slot either stalls acceptance forever or lets a second writer in. A faulty write-after-read check moves a write grant ahead of the read grant it depends on. The bench therefore checks the exact order of grant events and which units share a cycle, together with the stall level at chosen cycles.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NUM_UNITS = 5;
    localparam int NUM_REGS  = 32;
    localparam int OP_W      = 4;
    localparam int REG_W     = $clog2(NUM_REGS);
    localparam int UID_W     = $clog2(NUM_UNITS + 1);

    typedef enum logic [1:0] {CL_INT, CL_MUL, CL_ADD, CL_DIV} ucls_t;
    typedef enum logic [1:0] {PH_IDLE, PH_WAIT_RD, PH_EXEC, PH_WAIT_WB} phase_t;

    typedef logic [REG_W-1:0] reg_t;
    typedef logic [UID_W-1:0] uid_t;

    // Status entry of one functional unit; busy is phase != PH_IDLE
    typedef struct packed {
        phase_t          phase;
        logic [OP_W-1:0] op;
        reg_t            fi;
        reg_t            fj;
        reg_t            fk;
        uid_t            qj;
        uid_t            qk;
        logic            rj;
        logic            rk;
    } slot_t;

    // Reduced view used by the write-after-read check
    typedef struct packed {
        logic busy;
        reg_t fi;
        reg_t fj;
        reg_t fk;
        logic rj;
        logic rk;
    } war_view_t;

    // Unit index (0-based) to class
    function automatic ucls_t class_of(input int idx);
        case (idx)
            0:       return CL_INT;
            1, 2:    return CL_MUL;
            3:       return CL_ADD;
            default: return CL_DIV;
        endcase
    endfunction

    // True when producer tag q names a unit writing back in vector v
    function automatic logic tag_hit(input logic [NUM_UNITS-1:0] v, input uid_t q);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (q == uid_t'(i + 1) && v[i]) r = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel
    import sb_pkg::*;
(
    input  logic                 iss_valid,
    input  ucls_t                iss_cls,
    input  logic [NUM_UNITS-1:0] busy_v,
    input  uid_t                 dst_owner,
    output uid_t                 sel_uid,
    output logic                 issue_stall,
    output logic                 issue_fire
);
    logic found;

    always_comb begin
        found   = 1'b0;
        sel_uid = '0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (!found && class_of(i) == iss_cls && !busy_v[i]) begin
                found   = 1'b1;
                sel_uid = uid_t'(i + 1);
            end
        end
        issue_stall = iss_valid && (!found || dst_owner != '0);
        issue_fire  = iss_valid && !issue_stall;
    end
endmodule

// File: rtl/sb_result_tbl.sv
module sb_result_tbl
    import sb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_en,
    input  reg_t                 set_reg,
    input  uid_t                 set_uid,
    input  logic [NUM_UNITS-1:0] clr_vec,
    input  reg_t                 clr_reg [NUM_UNITS],
    input  reg_t                 rd_a,
    input  reg_t                 rd_b,
    input  reg_t                 rd_d,
    output uid_t                 q_a,
    output uid_t                 q_b,
    output uid_t                 q_d
);
    uid_t owner [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NUM_REGS; r++) owner[r] <= '0;
        end else begin
            for (int i = 0; i < NUM_UNITS; i++) begin
                if (clr_vec[i]) owner[clr_reg[i]] <= '0;
            end
            if (set_en) owner[set_reg] <= set_uid;
        end
    end

    assign q_a = owner[rd_a];
    assign q_b = owner[rd_b];
    assign q_d = owner[rd_d];

    // R3
    waw_free_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |-> owner[set_reg] == '0);

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_own
        // R7
        clr_owner_chk: assert property (@(posedge clk) disable iff (rst)
            clr_vec[g] |-> owner[clr_reg[g]] == uid_t'(g + 1));
    end
endmodule

// File: rtl/sb_war_check.sv
module sb_war_check
    import sb_pkg::*;
(
    input  war_view_t            view [NUM_UNITS],
    output logic [NUM_UNITS-1:0] wb_ok
);
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            wb_ok[u] = 1'b1;
            for (int f = 0; f < NUM_UNITS; f++) begin
                if (f != u && view[f].busy &&
                    ((view[f].fj == view[u].fi && view[f].rj) ||
                     (view[f].fk == view[u].fi && view[f].rk)))
                    wb_ok[u] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/sb_unit_slot.sv
module sb_unit_slot
    import sb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [OP_W-1:0]      op,
    input  reg_t                 dst,
    input  reg_t                 src1,
    input  reg_t                 src2,
    input  uid_t                 src_q1,
    input  uid_t                 src_q2,
    input  logic [NUM_UNITS-1:0] wb_vec,
    input  logic                 done,
    input  logic                 wb_ok,
    output slot_t                ent,
    output logic                 rd_grant,
    output logic                 wb_grant
);
    assign rd_grant = ent.phase == PH_WAIT_RD && ent.rj && ent.rk;
    assign wb_grant = ent.phase == PH_WAIT_WB && wb_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else if (load) begin
            ent.phase <= PH_WAIT_RD;
            ent.op    <= op;
            ent.fi    <= dst;
            ent.fj    <= src1;
            ent.fk    <= src2;
            ent.qj    <= src_q1;
            ent.qk    <= src_q2;
            ent.rj    <= src_q1 == '0;
            ent.rk    <= src_q2 == '0;
        end else begin
            case (ent.phase)
                PH_WAIT_RD: begin
                    if (rd_grant) begin
                        ent.phase <= PH_EXEC;
                        ent.rj    <= 1'b0;
                        ent.rk    <= 1'b0;
                        ent.qj    <= '0;
                        ent.qk    <= '0;
                    end else begin
                        if (tag_hit(wb_vec, ent.qj)) ent.rj <= 1'b1;
                        if (tag_hit(wb_vec, ent.qk)) ent.rk <= 1'b1;
                    end
                end
                PH_EXEC:    if (done) ent.phase <= PH_WAIT_WB;
                PH_WAIT_WB: if (wb_grant) ent <= '0;
                default:    ent <= '0;
            endcase
        end
    end

    // R4
    load_fill_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> ent.phase == PH_WAIT_RD && ent.fi == $past(dst) &&
                 ent.rj == ($past(src_q1) == '0) && ent.rk == ($past(src_q2) == '0));
    // R5
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd_grant |=> ent.phase == PH_EXEC && !ent.rj && !ent.rk);
    // R7
    wb_free_chk: assert property (@(posedge clk) disable iff (rst)
        wb_grant |=> ent.phase == PH_IDLE);
endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
    import sb_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      iss_valid,
    input  logic [OP_W-1:0]           iss_op,
    input  logic [1:0]                iss_cls,
    input  logic [REG_W-1:0]          iss_dst,
    input  logic [REG_W-1:0]          iss_src1,
    input  logic [REG_W-1:0]          iss_src2,
    input  logic [NUM_UNITS-1:0]      exec_done,
    output logic                      issue_stall,
    output logic [NUM_UNITS-1:0]      read_grant,
    output logic [NUM_UNITS-1:0]      wb_grant,
    output logic [NUM_UNITS*OP_W-1:0] unit_op
);
    slot_t                ents   [NUM_UNITS];
    war_view_t            views  [NUM_UNITS];
    reg_t                 dst_of [NUM_UNITS];
    logic [NUM_UNITS-1:0] busy_v;
    logic [NUM_UNITS-1:0] wb_ok;
    logic [NUM_UNITS-1:0] load_v;
    uid_t                 q1_raw, q2_raw, q_dst, q1, q2, sel_uid;
    logic                 fire;

    sb_issue_sel u_sel (
        .iss_valid  (iss_valid),
        .iss_cls    (ucls_t'(iss_cls)),
        .busy_v     (busy_v),
        .dst_owner  (q_dst),
        .sel_uid    (sel_uid),
        .issue_stall(issue_stall),
        .issue_fire (fire)
    );

    sb_result_tbl u_tbl (
        .clk    (clk),
        .rst    (rst),
        .set_en (fire),
        .set_reg(iss_dst),
        .set_uid(sel_uid),
        .clr_vec(wb_grant),
        .clr_reg(dst_of),
        .rd_a   (iss_src1),
        .rd_b   (iss_src2),
        .rd_d   (iss_dst),
        .q_a    (q1_raw),
        .q_b    (q2_raw),
        .q_d    (q_dst)
    );

    // A producer writing back in this cycle no longer blocks the new source
    assign q1 = tag_hit(wb_grant, q1_raw) ? '0 : q1_raw;
    assign q2 = tag_hit(wb_grant, q2_raw) ? '0 : q2_raw;

    sb_war_check u_war (
        .view (views),
        .wb_ok(wb_ok)
    );

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        assign load_v[g] = fire && sel_uid == uid_t'(g + 1);

        sb_unit_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .load    (load_v[g]),
            .op      (iss_op),
            .dst     (iss_dst),
            .src1    (iss_src1),
            .src2    (iss_src2),
            .src_q1  (q1),
            .src_q2  (q2),
            .wb_vec  (wb_grant),
            .done    (exec_done[g]),
            .wb_ok   (wb_ok[g]),
            .ent     (ents[g]),
            .rd_grant(read_grant[g]),
            .wb_grant(wb_grant[g])
        );

        assign busy_v[g]    = ents[g].phase != PH_IDLE;
        assign dst_of[g]    = ents[g].fi;
        assign views[g]     = '{busy: busy_v[g], fi: ents[g].fi, fj: ents[g].fj,
                                fk: ents[g].fk, rj: ents[g].rj, rk: ents[g].rk};
        assign unit_op[g*OP_W +: OP_W] = ents[g].op;

        // R6
        war_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (ents[g].phase == PH_WAIT_WB && !wb_grant[g]) |=> ents[g].phase == PH_WAIT_WB);
    end

    // R2
    struct_free_chk: assert property (@(posedge clk) disable iff (rst)
        (load_v & busy_v) == '0);
    // R1
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        issue_stall |-> load_v == '0);
endmodule

// File: tb/tb_sb_hazard_ctrl.sv
module tb_sb_hazard_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_op = '0;
    logic [1:0]  iss_cls = '0;
    logic [4:0]  iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [4:0]  exec_done = '0;
    logic        issue_stall;
    logic [4:0]  read_grant, wb_grant;
    logic [19:0] unit_op;

    always #5 clk = ~clk;

    sb_hazard_ctrl dut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_cls(iss_cls), .iss_dst(iss_dst), .iss_src1(iss_src1),
        .iss_src2(iss_src2), .exec_done(exec_done), .issue_stall(issue_stall),
        .read_grant(read_grant), .wb_grant(wb_grant), .unit_op(unit_op)
    );

    typedef struct {
        logic [4:0] rd;
        logic [4:0] wb;
        string      tag;
    } ev_t;

    ev_t exp_q[$];
    int  checks = 0;
    int  errors = 0;
    int  lat [5] = '{1, 3, 3, 1, 6};
    int  cnt [5] = '{0, 0, 0, 0, 0};

    localparam logic [1:0] C_INT = 2'd0, C_MUL = 2'd1, C_ADD = 2'd2, C_DIV = 2'd3;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input logic [4:0] rd, input logic [4:0] wb, input string tag);
        ev_t e;
        e.rd = rd; e.wb = wb; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: execution latency model and in-order comparison of grant events
    initial begin
        forever begin
            @(negedge clk);
            for (int i = 0; i < 5; i++) begin
                exec_done[i] = 1'b0;
                if (cnt[i] > 0) begin
                    cnt[i]--;
                    if (cnt[i] == 0) exec_done[i] = 1'b1;
                end
            end
            #4;
            if (!rst && (read_grant | wb_grant) != '0) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected grant", {read_grant, wb_grant}, 0);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    chk(read_grant == e.rd && wb_grant == e.wb, e.tag, "grant event",
                        {read_grant, wb_grant}, {e.rd, e.wb});
                end
            end
            for (int i = 0; i < 5; i++) begin
                if (!rst && read_grant[i]) cnt[i] = lat[i];
            end
        end
    end

    task automatic issue(input logic [1:0] cls, input logic [4:0] dst,
                         input logic [4:0] s1, input logic [4:0] s2, input logic [3:0] op);
        @(negedge clk);
        iss_cls = cls; iss_dst = dst; iss_src1 = s1; iss_src2 = s2; iss_op = op;
        iss_valid = 1'b1;
        #4;
        while (issue_stall) begin
            @(negedge clk);
            #4;
        end
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic try_stall(input logic [1:0] cls, input logic [4:0] dst,
                             input logic [4:0] s1, input logic [4:0] s2, input string req);
        @(negedge clk);
        iss_cls = cls; iss_dst = dst; iss_src1 = s1; iss_src2 = s2; iss_op = 4'hF;
        iss_valid = 1'b1;
        #4;
        chk(issue_stall == 1'b1, req, "issue_stall", issue_stall, 1);
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, req, "pending events", exp_q.size(), 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL R1 watchdog act=0 exp=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #4;
        // R9: grants low during reset
        chk(read_grant == '0 && wb_grant == '0, "R9", "grants in reset", {read_grant, wb_grant}, 0);
        @(negedge clk);
        rst = 1'b0;
        #4;
        // R9: idle after reset
        chk(issue_stall == 1'b0, "R9", "stall after reset", issue_stall, 0);
        chk(read_grant == '0 && wb_grant == '0, "R9", "grants after reset", {read_grant, wb_grant}, 0);

        // Test 1: divide, dependent add, integer subtract overwriting the add's source
        expect_ev(5'b10000, 5'b00000, "R5 divide reads");
        expect_ev(5'b00001, 5'b00000, "R4 subtract sources ready at issue");
        expect_ev(5'b00000, 5'b10000, "R6 divide writes");
        expect_ev(5'b01000, 5'b00000, "R7 add released only after divide write");
        expect_ev(5'b00000, 5'b00001, "R6 subtract write held until add read");
        expect_ev(5'b00000, 5'b01000, "R7 add writes");
        issue(C_DIV, 5'd0, 5'd2, 5'd4, 4'h3);
        issue(C_ADD, 5'd10, 5'd0, 5'd8, 4'h1);
        issue(C_INT, 5'd8, 5'd8, 5'd14, 4'h2);
        #1;
        chk(unit_op[3:0] == 4'h2, "R4", "integer unit op", unit_op[3:0], 2);
        try_stall(C_DIV, 5'd30, 5'd1, 5'd1, "R2 divider busy");
        drain("R6");

        // Test 2: two multiplies waiting on one divide are released together
        expect_ev(5'b10000, 5'b00000, "R5 divide reads");
        expect_ev(5'b00000, 5'b10000, "R7 divide writes");
        expect_ev(5'b00110, 5'b00000, "R8 both multipliers read together");
        expect_ev(5'b00000, 5'b00110, "R8 both multipliers write together");
        issue(C_DIV, 5'd2, 5'd3, 5'd5, 4'h3);
        issue(C_MUL, 5'd6, 5'd2, 5'd4, 4'h4);
        issue(C_MUL, 5'd12, 5'd2, 5'd5, 4'h5);
        #1;
        chk(unit_op[7:4] == 4'h4 && unit_op[11:8] == 4'h5, "R2", "lowest free multiplier first",
            unit_op[11:4], 8'h54);
        try_stall(C_MUL, 5'd20, 5'd1, 5'd1, "R2 both multipliers busy");
        drain("R8");

        // Test 3: write-after-write stall, then in-order follower
        expect_ev(5'b00010, 5'b00000, "R5 multiply reads");
        expect_ev(5'b00000, 5'b00010, "R3 multiply writes");
        expect_ev(5'b01000, 5'b00000, "R3 add reads after owner cleared");
        expect_ev(5'b00001, 5'b01000, "R1 follower reads only after add issued");
        expect_ev(5'b00000, 5'b00001, "R1 follower writes");
        issue(C_MUL, 5'd7, 5'd1, 5'd1, 4'h4);
        try_stall(C_ADD, 5'd7, 5'd1, 5'd1, "R3 destination owned");
        issue(C_ADD, 5'd7, 5'd1, 5'd1, 4'h1);
        issue(C_INT, 5'd9, 5'd1, 5'd1, 4'h2);
        drain("R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule